// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer for a 32-bit register bus. It has four word registers: control/status, counter, timeout and window. It can be reconfigured or serviced only through magic key values written to the counter address. A correct unlock key opens a short configuration window. A correct refresh key clears the running count. A wrong or unexpected key, written while the watchdog is enabled, is treated as runaway software and requests a system reset at once.

Software chooses between two key formats with control bit 13:
- **Two-write mode (bit 13 clear):** each key is a pair of 16-bit writes.
- **Single-write mode (bit 13 set):** each key is one 32-bit word.

The counter advances on one of four tick sources and can optionally divide that source by 256. When the count reaches the timeout value, the block either requests a reset at once, or first raises an interrupt and then allows a fixed grace period before the reset request.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the registers read as follows: control/status 0x00000020 (only the update-permit bit 5 set), counter 0, timeout 0x0000FFFF, window 0. Both outputs are low.
- R2: In two-write mode (control bit 13 = 0), unlocking takes two counter-address writes with low halves 0xC520 then 0xD928. Status bit 11 then reads 1 for 255 bus clocks and reads 0 after that.
- R3: In single-write mode (control bit 13 = 1), a single counter-address write unlocks or refreshes: 0xD928C520 unlocks and 0xB480A602 refreshes.
- R4: A write to control/status (offset 0x0), timeout (offset 0x8) or window (offset 0xC) is ignored in either of two cases: no unlock is open, or bit 5 was cleared by the configuration currently in force. As an exception, writing 1 to control bit 14 clears the timeout flag at any time.
- R5: An accepted control/status write does four things:
  - it applies bit 13 (key mode), bit 12 (divide by 256), bits 9:8 (tick source), bit 7 (run), bit 6 (interrupt enable) and bit 5 (update permit);
  - it clears the counter;
  - it sets status bit 10;
  - it closes the unlock, so bit 11 reads 0.
  A later accepted unlock clears bit 10.
- R6: A refresh clears the counter. In two-write mode the refresh is the pair 0xA602 then 0xB480.
- R7: A reset request is raised in the next clock in two cases:
  - the second write of a pair does not match the first, in either mode of the watchdog;
  - any unrecognised key is written while run (bit 7) is set.
  An unrecognised key written while run is clear has no effect.
- R8: Tick source 0 is the bus clock. Sources 1, 2 and 3 are `tickIn[0]`, `tickIn[1]` and `tickIn[2]`, and unselected ticks do not move the counter.
- R9: With bit 12 set, the counter advances once per 256 ticks of the selected source.
- R10: With interrupts disabled, the counter reaching the timeout value sets the timeout flag (bit 14) and the reset request in the same clock.
- R11: With interrupts enabled, reaching the timeout value sets the flag and `irqOut`. The reset request follows exactly 128 bus clocks later, unless a refresh occurs first.
- R12: When the window value is nonzero, a refresh while the counter is below the window value raises the reset request.
- R13: Once raised, the reset request stays high until the block reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe, one word per cycle |
| busAddr | input | 4 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| tickIn | input | 3 | Tick enables for sources 1 to 3 |
| irqOut | output | 1 | Timeout interrupt |
| rstReqOut | output | 1 | Sticky reset request |

## Verification
A table of key sequences covers both key modes, with the watchdog running and stopped. This separates three outcomes: a good unlock, a harmless stray write, and a fatal one. A design that punished stray writes while stopped, or that accepted a half-matching pair, fails there.

Directed tests probe three timing corners:
- **Unlock window:** it must close between 250 and 260 clocks.
- **Grace period:** the reset must still be low at 126 clocks and high by 130.
- **Prescaler:** after 300 ticks the count must be exactly 1.

A refresh issued inside the grace period must cancel the pending reset. Clearing the flag must not re-arm the timeout event. A refresh below a nonzero window must trip the reset. A block with the window compare inverted, or with an off-by-one grace count, would show a different reset level at one of these sample points.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // Key halves (two-write mode) and full words (single-write mode)
  localparam logic [15:0] KEY_OPEN_A  = 16'hC520;
  localparam logic [15:0] KEY_OPEN_B  = 16'hD928;
  localparam logic [15:0] KEY_FEED_A  = 16'hA602;
  localparam logic [15:0] KEY_FEED_B  = 16'hB480;
  localparam logic [31:0] KEY_OPEN_W  = {KEY_OPEN_B, KEY_OPEN_A};
  localparam logic [31:0] KEY_FEED_W  = {KEY_FEED_B, KEY_FEED_A};

  // Register byte addresses
  localparam logic [3:0] ADR_CTRL = 4'h0;
  localparam logic [3:0] ADR_CNT  = 4'h4;
  localparam logic [3:0] ADR_TOV  = 4'h8;
  localparam logic [3:0] ADR_WIN  = 4'hC;

  typedef enum logic [1:0] {
    SRC_BUS  = 2'd0,
    SRC_LOW  = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_EXT  = 2'd3
  } tickSrcE;

  typedef enum logic [1:0] {
    PEND_NONE,
    PEND_OPEN,
    PEND_FEED
  } pendE;

  // Configuration visible to the datapath
  typedef struct packed {
    logic    preDiv;
    tickSrcE src;
    logic    run;
    logic    irqEn;
  } runCfgT;

  // One-cycle strobes from control to datapath
  typedef struct packed {
    logic refresh;
    logic apply;
    logic keyFault;
    logic flagClr;
  } strobeT;

endpackage

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int TO_W          = 16,
  parameter int UNLOCK_CYCLES = 255
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busWr,
  input  logic [3:0]      busAddr,
  input  logic [31:0]     busWdata,
  input  logic [TO_W-1:0] cntVal,
  input  logic            flagIn,
  output logic [31:0]     busRdata,
  output runCfgT          runCfg,
  output logic [TO_W-1:0] tovalOut,
  output logic [TO_W-1:0] winOut,
  output strobeT          stb
);

  localparam int UL_W = $clog2(UNLOCK_CYCLES + 1);
  localparam logic [UL_W-1:0] UL_LOAD = UL_W'(UNLOCK_CYCLES);

  logic            wideQ;
  logic            updOkQ;
  runCfgT          runQ;
  logic [TO_W-1:0] tovalQ;
  logic [TO_W-1:0] winQ;
  logic [UL_W-1:0] ulkCnt;
  logic            rcsQ;
  pendE            pendQ;
  pendE            pendNext;

  logic ulkOpen;
  logic cfgOk;
  logic wrCtrl;
  logic wrCnt;
  logic wrTov;
  logic wrWin;
  logic unlockGo;
  logic refreshGo;
  logic fault;

  assign ulkOpen = (ulkCnt != '0);
  assign cfgOk   = ulkOpen && updOkQ;
  assign wrCtrl  = busWr && (busAddr == ADR_CTRL);
  assign wrCnt   = busWr && (busAddr == ADR_CNT);
  assign wrTov   = busWr && (busAddr == ADR_TOV);
  assign wrWin   = busWr && (busAddr == ADR_WIN);

  // Key decoder
  always_comb begin
    unlockGo  = 1'b0;
    refreshGo = 1'b0;
    fault     = 1'b0;
    pendNext  = pendQ;
    if (wrCnt) begin
      if (wideQ) begin
        pendNext = PEND_NONE;
        if (busWdata == KEY_OPEN_W)      unlockGo  = 1'b1;
        else if (busWdata == KEY_FEED_W) refreshGo = 1'b1;
        else if (runQ.run)               fault     = 1'b1;
      end else begin
        case (pendQ)
          PEND_OPEN: begin
            pendNext = PEND_NONE;
            if (busWdata[15:0] == KEY_OPEN_B) unlockGo = 1'b1;
            else                              fault    = 1'b1;
          end
          PEND_FEED: begin
            pendNext = PEND_NONE;
            if (busWdata[15:0] == KEY_FEED_B) refreshGo = 1'b1;
            else                              fault     = 1'b1;
          end
          default: begin
            if (busWdata[15:0] == KEY_OPEN_A)      pendNext = PEND_OPEN;
            else if (busWdata[15:0] == KEY_FEED_A) pendNext = PEND_FEED;
            else if (runQ.run)                     fault    = 1'b1;
          end
        endcase
      end
    end
  end

  assign stb.refresh  = refreshGo;
  assign stb.apply    = wrCtrl && cfgOk;
  assign stb.keyFault = fault;
  assign stb.flagClr  = wrCtrl && busWdata[14];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ  <= PEND_NONE;
      ulkCnt <= '0;
      rcsQ   <= 1'b0;
    end else begin
      pendQ <= pendNext;
      if (unlockGo) begin
        ulkCnt <= UL_LOAD;
        rcsQ   <= 1'b0;
      end else if (stb.apply) begin
        ulkCnt <= '0;
        rcsQ   <= 1'b1;
      end else if (ulkOpen) begin
        ulkCnt <= ulkCnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wideQ  <= 1'b0;
      updOkQ <= 1'b1;
      runQ   <= '{preDiv: 1'b0, src: SRC_BUS, run: 1'b0, irqEn: 1'b0};
      tovalQ <= '1;
      winQ   <= '0;
    end else begin
      if (stb.apply) begin
        wideQ       <= busWdata[13];
        runQ.preDiv <= busWdata[12];
        runQ.src    <= tickSrcE'(busWdata[9:8]);
        runQ.run    <= busWdata[7];
        runQ.irqEn  <= busWdata[6];
        updOkQ      <= busWdata[5];
      end
      if (wrTov && cfgOk) tovalQ <= busWdata[TO_W-1:0];
      if (wrWin && cfgOk) winQ   <= busWdata[TO_W-1:0];
    end
  end

  always_comb begin
    case (busAddr)
      ADR_CTRL: busRdata = {17'b0, flagIn, wideQ, runQ.preDiv, ulkOpen, rcsQ,
                            runQ.src, runQ.run, runQ.irqEn, updOkQ, 5'b0};
      ADR_CNT:  busRdata = 32'(cntVal);
      ADR_TOV:  busRdata = 32'(tovalQ);
      ADR_WIN:  busRdata = 32'(winQ);
      default:  busRdata = '0;
    endcase
  end

  assign runCfg   = runQ;
  assign tovalOut = tovalQ;
  assign winOut   = winQ;

  // R4
  locked_tov_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrTov && !cfgOk) |=> $stable(tovalQ));

  // R2
  unlock_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    unlockGo |=> ulkOpen);

  // R5
  apply_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.apply && !unlockGo) |=> (!ulkOpen && rcsQ));

endmodule

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int TO_W         = 16,
  parameter int PRESCALE_W   = 8,
  parameter int GRACE_CYCLES = 128
) (
  input  logic            clk,
  input  logic            rstN,
  input  runCfgT          runCfg,
  input  logic [TO_W-1:0] toval,
  input  logic [TO_W-1:0] win,
  input  strobeT          stb,
  input  logic [2:0]      tickIn,
  output logic [TO_W-1:0] cntVal,
  output logic            flagOut,
  output logic            irqOut,
  output logic            rstReqOut
);

  localparam int GR_W = $clog2(GRACE_CYCLES);
  localparam logic [GR_W-1:0] GR_LAST = GR_W'(GRACE_CYCLES - 1);

  logic            tickSel;
  logic            step;
  logic [TO_W-1:0] cntQ;
  logic            toSeenQ;
  logic            flagQ;
  logic            graceOn;
  logic [GR_W-1:0] graceCnt;
  logic            rstReqQ;
  logic            hit;
  logic            toEvent;
  logic            graceDone;
  logic            winFault;

  always_comb begin
    case (runCfg.src)
      SRC_BUS:  tickSel = 1'b1;
      SRC_LOW:  tickSel = tickIn[0];
      SRC_SLOW: tickSel = tickIn[1];
      default:  tickSel = tickIn[2];
    endcase
  end

  generate
    if (PRESCALE_W > 0) begin : gPre
      logic [PRESCALE_W-1:0] preQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                          preQ <= '0;
        else if (stb.apply)                 preQ <= '0;
        else if (tickSel && runCfg.preDiv)  preQ <= preQ + 1'b1;
      end
      assign step = runCfg.preDiv ? (tickSel && (&preQ)) : tickSel;
    end else begin : gNoPre
      assign step = tickSel;
    end
  endgenerate

  assign hit       = runCfg.run && (cntQ >= toval);
  assign toEvent   = hit && !toSeenQ;
  assign graceDone = graceOn && (graceCnt == GR_LAST);
  assign winFault  = stb.refresh && (win != '0) && (cntQ < win);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      toSeenQ <= 1'b0;
    end else if (stb.apply || stb.refresh) begin
      cntQ    <= '0;
      toSeenQ <= 1'b0;
    end else begin
      if (runCfg.run && step && (cntQ < toval)) cntQ <= cntQ + 1'b1;
      if (hit) toSeenQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ    <= 1'b0;
      graceOn  <= 1'b0;
      graceCnt <= '0;
      rstReqQ  <= 1'b0;
    end else begin
      if (toEvent)          flagQ <= 1'b1;
      else if (stb.flagClr) flagQ <= 1'b0;

      if (stb.apply || stb.refresh) begin
        graceOn  <= 1'b0;
        graceCnt <= '0;
      end else if (toEvent && runCfg.irqEn) begin
        graceOn  <= 1'b1;
        graceCnt <= '0;
      end else if (graceDone) begin
        graceOn  <= 1'b0;
      end else if (graceOn) begin
        graceCnt <= graceCnt + 1'b1;
      end

      if (stb.keyFault || winFault || graceDone || (toEvent && !runCfg.irqEn))
        rstReqQ <= 1'b1;
    end
  end

  assign cntVal    = cntQ;
  assign flagOut   = flagQ;
  assign irqOut    = flagQ && runCfg.irqEn;
  assign rstReqOut = rstReqQ;

  // R13
  reset_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReqQ |=> rstReqQ);

  // R6
  refresh_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.refresh |=> (cntQ == '0));

  // R10
  nointr_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(flagQ) && !$past(runCfg.irqEn)) |-> rstReqQ);

  // R11
  intr_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (graceOn && !stb.keyFault && !winFault && !graceDone) |=> (flagQ || stb.flagClr || $past(stb.flagClr) || !rstReqQ || $past(rstReqQ)));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdg_pkg::*;
#(
  parameter int TO_W          = 16,
  parameter int PRESCALE_W    = 8,
  parameter int UNLOCK_CYCLES = 255,
  parameter int GRACE_CYCLES  = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [3:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic [2:0]  tickIn,
  output logic        irqOut,
  output logic        rstReqOut
);

  runCfgT          runCfg;
  strobeT          stb;
  logic [TO_W-1:0] toval;
  logic [TO_W-1:0] win;
  logic [TO_W-1:0] cntVal;
  logic            flag;

  wdg_ctrl #(
    .TO_W          (TO_W),
    .UNLOCK_CYCLES (UNLOCK_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .cntVal   (cntVal),
    .flagIn   (flag),
    .busRdata (busRdata),
    .runCfg   (runCfg),
    .tovalOut (toval),
    .winOut   (win),
    .stb      (stb)
  );

  wdg_datapath #(
    .TO_W         (TO_W),
    .PRESCALE_W   (PRESCALE_W),
    .GRACE_CYCLES (GRACE_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .runCfg    (runCfg),
    .toval     (toval),
    .win       (win),
    .stb       (stb),
    .tickIn    (tickIn),
    .cntVal    (cntVal),
    .flagOut   (flag),
    .irqOut    (irqOut),
    .rstReqOut (rstReqOut)
  );

endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busWr;
  logic [3:0]  busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic [2:0]  tickIn;
  logic        irqOut;
  logic        rstReqOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  keyed_watchdog u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .tickIn    (tickIn),
    .irqOut    (irqOut),
    .rstReqOut (rstReqOut)
  );

  // {mode32, run, useSecond, expUnlocked, expResetReq, word0, word1}
  localparam int NV = 10;
  localparam logic [68:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000C520, 32'h0000D928},
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000C520, 32'h0000D928},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000C520, 32'h00001234},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00005555, 32'h00000000},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00005555, 32'h00000000},
    {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'hD928C520, 32'h00000000},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000C520, 32'h00000000},
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000C520, 32'h00000000},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000A602, 32'h0000B480},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000A602, 32'h0000D928}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic doReset();
    rstN = 1'b0; busWr = 1'b0; busAddr = 4'h0; busWdata = '0; tickIn = 3'b000;
    waitn(3);
    rstN = 1'b1;
    waitn(1);
  endtask

  task automatic unlock16();
    wr(4'h4, 32'h0000C520);
    wr(4'h4, 32'h0000D928);
  endtask

  task automatic refresh16();
    wr(4'h4, 32'h0000A602);
    wr(4'h4, 32'h0000B480);
  endtask

  task automatic setup(input logic [31:0] cs, input logic [31:0] tov, input logic [31:0] wv);
    unlock16();
    wr(4'h8, tov);
    wr(4'hC, wv);
    wr(4'h0, cs);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL bench watchdog expired (all requirements) actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [68:0] v;
    logic [31:0] cs;
    logic [31:0] tovKeep;

    doReset();

    // R1 reset state
    rd(4'h0, rv); check("R1 ctrl reset", rv, 32'h20);
    rd(4'h4, rv); check("R1 count reset", rv, 32'h0);
    rd(4'h8, rv); check("R1 timeout reset", rv, 32'hFFFF);
    rd(4'hC, rv); check("R1 window reset", rv, 32'h0);
    check("R1 outputs reset", {30'b0, irqOut, rstReqOut}, 32'h0);

    // R2 R3 R7 key table
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      doReset();
      cs = 32'h120 | (v[68] ? 32'h2000 : 32'h0) | (v[67] ? 32'h80 : 32'h0);
      setup(cs, 32'hFFFF, 32'h0);
      wr(4'h4, v[63:32]);
      if (v[66]) wr(4'h4, v[31:0]);
      rd(4'h0, rv);
      check($sformatf("R2 R3 R7 table %0d unlock bit", i), {31'b0, rv[11]}, {31'b0, v[65]});
      check($sformatf("R2 R3 R7 table %0d reset req", i), {31'b0, rstReqOut}, {31'b0, v[64]});
    end

    // R4 locked writes ignored
    doReset();
    wr(4'h8, 32'h1234);
    rd(4'h8, rv); check("R4 timeout write while locked", rv, 32'hFFFF);
    // R2 unlock expires
    unlock16();
    waitn(250);
    rd(4'h0, rv); check("R2 unlock still open at 250", {31'b0, rv[11]}, 32'h1);
    waitn(10);
    rd(4'h0, rv); check("R2 unlock closed after 260", {31'b0, rv[11]}, 32'h0);
    wr(4'h8, 32'h4321);
    rd(4'h8, rv); check("R4 timeout write after unlock expiry", rv, 32'hFFFF);

    // R5 apply flags, R4 permit cleared
    doReset();
    setup(32'h00000000, 32'h0777, 32'h0);
    rd(4'h0, rv); check("R5 applied bit10 set bit11 clear", rv & 32'hC20, 32'h400);
    unlock16();
    rd(4'h0, rv); check("R5 unlock clears bit10", rv & 32'hC00, 32'h800);
    wr(4'h8, 32'h0055);
    rd(4'h8, rv); check("R4 permit cleared blocks timeout", rv, 32'h0777);

    // R6 refresh clears counter
    doReset();
    setup(32'hA0, 32'h03E8, 32'h0);
    waitn(40);
    refresh16();
    rd(4'h4, rv); check("R6 refresh clears count", rv, 32'h0);

    // R3 single-write refresh
    doReset();
    setup(32'h20A0, 32'h03E8, 32'h0);
    waitn(30);
    wr(4'h4, 32'hB480A602);
    rd(4'h4, rv); check("R3 single-word refresh", rv, 32'h0);
    check("R3 single-word refresh no reset", {31'b0, rstReqOut}, 32'h0);

    // R8 tick source select: external source, source-1 held high
    doReset();
    setup(32'h3A0, 32'h03E8, 32'h0);
    tickIn = 3'b001;
    for (int k = 0; k < 10; k++) begin
      tickIn[2] = 1'b1; waitn(1);
      tickIn[2] = 1'b0; waitn(1);
    end
    rd(4'h4, rv); check("R8 external ticks counted", rv, 32'd10);
    tickIn = 3'b000;

    // R9 prescaler
    doReset();
    setup(32'h10A0, 32'h03E8, 32'h0);
    waitn(300);
    rd(4'h4, rv); check("R9 divide by 256", rv, 32'd1);

    // R10 timeout without interrupt
    doReset();
    setup(32'hA0, 32'd20, 32'h0);
    waitn(15);
    check("R10 no reset before timeout", {31'b0, rstReqOut}, 32'h0);
    waitn(15);
    check("R10 reset at timeout", {31'b0, rstReqOut}, 32'h1);
    rd(4'h0, rv); check("R10 flag set", {31'b0, rv[14]}, 32'h1);
    check("R10 no irq", {31'b0, irqOut}, 32'h0);
    // R13 sticky
    refresh16();
    waitn(20);
    check("R13 reset request sticky", {31'b0, rstReqOut}, 32'h1);

    // R11 exact grace
    doReset();
    setup(32'hE0, 32'd10, 32'h0);
    for (int k = 0; k < 60 && !irqOut; k++) waitn(1);
    check("R11 irq raised", {31'b0, irqOut}, 32'h1);
    waitn(126);
    check("R11 no reset at 126", {31'b0, rstReqOut}, 32'h0);
    waitn(4);
    check("R11 reset by 130", {31'b0, rstReqOut}, 32'h1);

    // R11 refresh cancels grace, flag clear
    doReset();
    setup(32'hE0, 32'd10, 32'h0);
    for (int k = 0; k < 60 && !irqOut; k++) waitn(1);
    waitn(100);
    refresh16();
    waitn(60);
    check("R11 refresh cancels reset", {31'b0, rstReqOut}, 32'h0);
    wr(4'h0, 32'h4000);
    check("R4 flag clear while locked drops irq", {31'b0, irqOut}, 32'h0);
    rd(4'h8, tovKeep); check("R4 ctrl write while locked leaves timeout", tovKeep, 32'd10);
    waitn(100);
    check("R11 second grace expires", {31'b0, rstReqOut}, 32'h1);

    // R12 window
    doReset();
    setup(32'hA0, 32'd1000, 32'd50);
    refresh16();
    check("R12 early refresh resets", {31'b0, rstReqOut}, 32'h1);
    doReset();
    setup(32'hA0, 32'd1000, 32'd50);
    waitn(80);
    refresh16();
    check("R12 late refresh accepted", {31'b0, rstReqOut}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule